// File: doc/BRIEF.md
# Banked Debug Message Emitter

This block lets software running on several CPUs send tagged debug messages out of a chip through a small set of write-only registers. Each CPU, named by a cluster number and a CPU number on the write bus sideband, has its own private copy of three 64-bit scratch values and its own character buffer. Software fills the scratch values, then writes the characters of a text one byte at a time. A final zero byte closes the message.

When the message closes, the block produces one event record on a valid/ready output. The record holds a global sequence number, the packed identity of the writer, the writer's three scratch values, the collected text, its length and an overflow flag. The writer's text buffer then starts empty again. The scratch values stay as they are. Up to four copies of the register window are decoded. A parameter says which of them exist, and writes to absent copies are quietly accepted and dropped.

Top module: `dbg_msg_emitter`

## Requirements
- R1: After reset `evValid` is 0 and `wReady` is 1.
- R2: Byte address bits [4:2] select a word. Words 0 to 5 are scratch halves: scratch register n = word/2, an even word writes bits [31:0] and an odd word writes bits [63:32] from `wData`. Scratch values keep their contents across events until written again.
- R3: A write to word 6 with a nonzero `wData[7:0]` appends that byte to the writer's text. In the event, text byte i sits at `evMsg[8*i+7:8*i]` in write order, and bytes past the text are zero.
- R4: A write to word 6 with `wData[7:0]` equal to 0 raises `evValid` on the next cycle. The event carries the writer's three scratch values and text, and `evLen` equals the number of stored characters plus one.
- R5: `evSeq` is 1 for the first event after reset and rises by exactly one for each later event, whichever CPU sends it.
- R6: `evId` equals `{wCluster, wCpu}` of the writer whose zero byte made the event.
- R7: Each (cluster, CPU) pair has its own scratch values and text buffer. Writes from one pair never change what another pair's event reports.
- R8: After an event, the sender's text buffer is empty and its overflow flag is clear. The next event from that sender holds only characters written after the previous one.
- R9: A text buffer holds 64 characters. Further characters are dropped. The event then reports `evOverflow` = 1 and `evLen` = 65.
- R10: Address bits [6:5] pick one of four windows, and only windows whose bit is set in `PRESENT` (default: window 0 only) respond. A write to an absent window, to word 7, or with a cluster or CPU number beyond the configured counts is accepted and has no effect: it makes no event and changes no stored value.
- R11: `evValid` stays high with a stable payload until `evReady` is seen high. While an event waits, a closing zero-byte write is held with `wReady` low until the waiting event is taken. It is then accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wValid | input | 1 | Write request present |
| wReady | output | 1 | Write accepted this cycle when high together with wValid |
| wAddr | input | 7 | Byte address: window in [6:5], word in [4:2] |
| wData | input | 32 | Write data; character in [7:0] |
| wCluster | input | 8 | Cluster number of the writer |
| wCpu | input | 8 | CPU number of the writer within its cluster |
| evValid | output | 1 | Event record present |
| evReady | input | 1 | Consumer takes the event |
| evSeq | output | 32 | Event sequence number |
| evId | output | 16 | Writer identity {cluster, cpu} |
| evData0 | output | 64 | Scratch register 0 |
| evData1 | output | 64 | Scratch register 1 |
| evData2 | output | 64 | Scratch register 2 |
| evMsg | output | 512 | Collected text, byte 0 in the low bits |
| evLen | output | 7 | Characters plus terminator |
| evOverflow | output | 1 | Text was truncated |

## Verification
The assertions check the per-cycle rules on every cycle. A waiting event keeps its sequence number and identity. The sequence number steps by one per emitted event. Held writes happen only while an event is pending. No text counter passes its capacity. A buffer is empty right after its owner emits. An overflow flag always comes with the full length. Other properties depend on content and order, and only the bench scenarios show them. These cover the byte order of the text and the zeroed tail, scratch persistence, isolation between interleaved writers, and that dropped writes leave no trace. They also cover the exact moment a stalled closing write gets through.

// File: rtl/dbg_msg_emitter_pkg.sv
package dbg_msg_emitter_pkg;

  // word index that carries characters
  localparam logic [2:0] WORD_CHAR = 3'd6;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic       dataWr;  // write a scratch half
    logic [2:0] word;    // word index of the write
    logic       charWr;  // append a character
    logic       emit;    // capture an event record
  } strobe_t;

endpackage

// File: rtl/dbg_msg_emitter_ctrl.sv
module dbg_msg_emitter_ctrl
  import dbg_msg_emitter_pkg::*;
#(
  parameter int INSTANCES = 4,
  parameter logic [INSTANCES-1:0] PRESENT = 4'b0001,
  parameter int CLUSTERS = 2,
  parameter int CPUS = 2,
  parameter int ADDR_W = 5 + $clog2(INSTANCES),
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wValid,
  output logic              wReady,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [7:0]        wChar,
  input  logic [7:0]        wCluster,
  input  logic [7:0]        wCpu,
  input  logic              evReady,
  output strobe_t           strb,
  output logic [BANK_W-1:0] bank,
  output logic              evValid,
  output logic [31:0]       evSeq,
  output logic [15:0]       evId
);

  localparam int INST_W = ADDR_W - 5;
  localparam logic [7:0] CLUSTER_LIM = 8'(CLUSTERS);
  localparam logic [7:0] CPU_LIM = 8'(CPUS);

  logic [INST_W-1:0] instSel;
  logic [2:0]        word;
  logic              instOk, idOk, hit, isNul, stall, accept;

  assign instSel = wAddr[5 +: INST_W];
  assign word    = wAddr[4:2];
  assign instOk  = PRESENT[instSel];
  assign idOk    = (wCluster < CLUSTER_LIM) && (wCpu < CPU_LIM);
  assign hit     = wValid && instOk && idOk;
  assign isNul   = hit && (word == WORD_CHAR) && (wChar == 8'd0);
  assign stall   = evValid && !evReady;
  assign wReady  = !(isNul && stall);
  assign accept  = wValid && wReady;
  assign bank    = BANK_W'(int'(wCluster) * CPUS + int'(wCpu));

  always_comb begin
    strb        = '0;
    strb.word   = word;
    strb.dataWr = accept && hit && (word < WORD_CHAR);
    strb.charWr = accept && hit && (word == WORD_CHAR) && (wChar != 8'd0);
    strb.emit   = accept && isNul;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evValid <= 1'b0;
      evSeq   <= '0;
      evId    <= '0;
    end else begin
      if (strb.emit) begin
        evValid <= 1'b1;
        evSeq   <= evSeq + 32'd1;
        evId    <= {wCluster, wCpu};
      end else if (evReady) begin
        evValid <= 1'b0;
      end
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid && !evReady |=> evValid && $stable(evSeq) && $stable(evId));

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit |=> evSeq == $past(evSeq) + 32'd1);

  // R11
  held_only_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    wValid && !wReady |-> evValid && !evReady);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.dataWr, strb.charWr, strb.emit}));

endmodule

// File: rtl/dbg_msg_emitter_dp.sv
module dbg_msg_emitter_dp
  import dbg_msg_emitter_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BANK_W = 2,
  parameter int DEPTH = 64,
  parameter int LEN_W = $clog2(DEPTH + 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [BANK_W-1:0]    bank,
  input  logic [31:0]          wData,
  output logic [63:0]          evData0,
  output logic [63:0]          evData1,
  output logic [63:0]          evData2,
  output logic [DEPTH*8-1:0]   evMsg,
  output logic [LEN_W-1:0]     evLen,
  output logic                 evOverflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LEN_W-1:0] CAP = LEN_W'(DEPTH);

  logic [63:0]      scratch [BANKS][3];
  logic [7:0]       msgMem  [BANKS][DEPTH];
  logic [LEN_W-1:0] cnt     [BANKS];
  logic             ovf     [BANKS];
  logic [DEPTH*8-1:0] msgNext;

  // scratch registers, counters and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < BANKS; b++) begin
        for (int r = 0; r < 3; r++) scratch[b][r] <= '0;
        cnt[b] <= '0;
        ovf[b] <= 1'b0;
      end
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (bank == BANK_W'(b)) begin
          if (strb.dataWr) begin
            for (int r = 0; r < 3; r++) begin
              if (strb.word[2:1] == 2'(r)) begin
                if (strb.word[0]) scratch[b][r][63:32] <= wData;
                else              scratch[b][r][31:0]  <= wData;
              end
            end
          end
          if (strb.charWr) begin
            if (cnt[b] < CAP) cnt[b] <= cnt[b] + 1'b1;
            else              ovf[b] <= 1'b1;
          end
          if (strb.emit) begin
            cnt[b] <= '0;
            ovf[b] <= 1'b0;
          end
        end
      end
    end
  end

  // character storage, no reset needed: the counter masks stale bytes
  always_ff @(posedge clk) begin
    for (int b = 0; b < BANKS; b++) begin
      if (strb.charWr && bank == BANK_W'(b) && cnt[b] < CAP)
        msgMem[b][cnt[b][PTR_W-1:0]] <= wData[7:0];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      msgNext[i*8 +: 8] = (LEN_W'(i) < cnt[bank]) ? msgMem[bank][i] : 8'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evData0    <= '0;
      evData1    <= '0;
      evData2    <= '0;
      evMsg      <= '0;
      evLen      <= '0;
      evOverflow <= 1'b0;
    end else if (strb.emit) begin
      evData0    <= scratch[bank][0];
      evData1    <= scratch[bank][1];
      evData2    <= scratch[bank][2];
      evMsg      <= msgNext;
      evLen      <= cnt[bank] + 1'b1;
      evOverflow <= ovf[bank];
    end
  end

  generate
    for (genvar g = 0; g < BANKS; g++) begin : g_bankChk
      // R9
      cap_chk: assert property (@(posedge clk) disable iff (!rstN)
        cnt[g] <= CAP);
      // R8
      clear_after_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.emit && bank == BANK_W'(g) |=> cnt[g] == '0 && !ovf[g]);
    end
  endgenerate

  // R9
  ovf_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    evOverflow |-> evLen == CAP + 1'b1);

  // R4
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit |=> evLen != '0);

endmodule

// File: rtl/dbg_msg_emitter.sv
module dbg_msg_emitter
  import dbg_msg_emitter_pkg::*;
#(
  parameter int INSTANCES = 4,
  parameter logic [INSTANCES-1:0] PRESENT = 4'b0001,
  parameter int CLUSTERS = 2,
  parameter int CPUS = 2,
  parameter int DEPTH = 64,
  parameter int ADDR_W = 5 + $clog2(INSTANCES),
  parameter int LEN_W = $clog2(DEPTH + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wValid,
  output logic               wReady,
  input  logic [ADDR_W-1:0]  wAddr,
  input  logic [31:0]        wData,
  input  logic [7:0]         wCluster,
  input  logic [7:0]         wCpu,
  output logic               evValid,
  input  logic               evReady,
  output logic [31:0]        evSeq,
  output logic [15:0]        evId,
  output logic [63:0]        evData0,
  output logic [63:0]        evData1,
  output logic [63:0]        evData2,
  output logic [DEPTH*8-1:0] evMsg,
  output logic [LEN_W-1:0]   evLen,
  output logic               evOverflow
);

  localparam int BANKS  = CLUSTERS * CPUS;
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  strobe_t           strb;
  logic [BANK_W-1:0] bank;

  dbg_msg_emitter_ctrl #(
    .INSTANCES(INSTANCES), .PRESENT(PRESENT), .CLUSTERS(CLUSTERS),
    .CPUS(CPUS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wValid(wValid), .wReady(wReady),
    .wAddr(wAddr), .wChar(wData[7:0]), .wCluster(wCluster), .wCpu(wCpu),
    .evReady(evReady), .strb(strb), .bank(bank),
    .evValid(evValid), .evSeq(evSeq), .evId(evId)
  );

  dbg_msg_emitter_dp #(
    .BANKS(BANKS), .BANK_W(BANK_W), .DEPTH(DEPTH), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bank(bank), .wData(wData),
    .evData0(evData0), .evData1(evData1), .evData2(evData2),
    .evMsg(evMsg), .evLen(evLen), .evOverflow(evOverflow)
  );

endmodule

// File: tb/dbg_msg_emitter_tb.sv
module dbg_msg_emitter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wValid = 1'b0;
  logic wReady;
  logic [6:0] wAddr = '0;
  logic [31:0] wData = '0;
  logic [7:0] wCluster = '0, wCpu = '0;
  logic evValid, evReady = 1'b0;
  logic [31:0] evSeq;
  logic [15:0] evId;
  logic [63:0] evData0, evData1, evData2;
  logic [DEPTH*8-1:0] evMsg;
  logic [6:0] evLen;
  logic evOverflow;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_msg_emitter u_dut (
    .clk(clk), .rstN(rstN), .wValid(wValid), .wReady(wReady),
    .wAddr(wAddr), .wData(wData), .wCluster(wCluster), .wCpu(wCpu),
    .evValid(evValid), .evReady(evReady), .evSeq(evSeq), .evId(evId),
    .evData0(evData0), .evData1(evData1), .evData2(evData2),
    .evMsg(evMsg), .evLen(evLen), .evOverflow(evOverflow)
  );

  task automatic check(string req, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [511:0] strVec(string s);
    logic [511:0] m = '0;
    for (int i = 0; i < s.len(); i++) m[i*8 +: 8] = s[i];
    return m;
  endfunction

  task automatic wr(int inst, int word, logic [31:0] d, int cl, int cpu);
    @(negedge clk);
    wValid = 1'b1; wAddr = {2'(inst), 3'(word), 2'b00}; wData = d;
    wCluster = 8'(cl); wCpu = 8'(cpu);
    #1;
    while (!wReady) @(negedge clk);
    @(posedge clk);
    #1 wValid = 1'b0;
  endtask

  task automatic setData(int cl, int cpu, int r, logic [63:0] v);
    wr(0, 2*r, v[31:0], cl, cpu);
    wr(0, 2*r+1, v[63:32], cl, cpu);
  endtask

  task automatic sendStr(int cl, int cpu, string s);
    for (int i = 0; i < s.len(); i++) wr(0, 6, 32'(s[i]), cl, cpu);
  endtask

  task automatic expectEv(string req, int seq, logic [15:0] id, logic [63:0] d0,
                          logic [63:0] d1, logic [63:0] d2, logic [511:0] msg,
                          int len, logic ovf);
    int n = 0;
    @(negedge clk);
    while (!evValid && n < 50) begin @(negedge clk); n++; end
    check(req, "evValid", 512'(evValid), 512'(1));
    check(req, "evSeq", 512'(evSeq), 512'(seq));
    check(req, "evId", 512'(evId), 512'(id));
    check(req, "evData0", 512'(evData0), 512'(d0));
    check(req, "evData1", 512'(evData1), 512'(d1));
    check(req, "evData2", 512'(evData2), 512'(d2));
    check(req, "evMsg", evMsg, msg);
    check(req, "evLen", 512'(evLen), 512'(len));
    check(req, "evOverflow", 512'(evOverflow), 512'(ovf));
    evReady = 1'b1;
    @(posedge clk);
    #1 evReady = 1'b0;
  endtask

  localparam logic [63:0] D0 = 64'h1122334455667788;
  localparam logic [63:0] D1 = 64'h0123456789abcdef;
  localparam logic [63:0] D2 = 64'hdeadbeefcafef00d;

  task automatic tReset();
    @(negedge clk);
    check("R1", "evValid after reset", 512'(evValid), 512'(0));
    check("R1", "wReady after reset", 512'(wReady), 512'(1));
  endtask

  task automatic tBasic();  // R2 R3 R4 R5 R6
    setData(0, 0, 0, D0);
    setData(0, 0, 1, D1);
    setData(0, 0, 2, D2);
    sendStr(0, 0, "Hi");
    wr(0, 6, 0, 0, 0);
    expectEv("R4", 1, 16'h0000, D0, D1, D2, strVec("Hi"), 3, 1'b0);
  endtask

  task automatic tPersist();  // R2 R8
    sendStr(0, 0, "Yo");
    wr(0, 6, 0, 0, 0);
    expectEv("R8", 2, 16'h0000, D0, D1, D2, strVec("Yo"), 3, 1'b0);
    wr(0, 6, 0, 0, 0);
    expectEv("R2", 3, 16'h0000, D0, D1, D2, '0, 1, 1'b0);
  endtask

  task automatic tBanks();  // R6 R7
    setData(1, 1, 0, 64'hAAAA0000BBBB1111);
    setData(0, 1, 0, 64'h5555666677778888);
    wr(0, 6, 32'h70, 1, 1);
    wr(0, 6, 32'h71, 0, 1);
    wr(0, 6, 32'h72, 1, 1);
    wr(0, 6, 0, 1, 1);
    expectEv("R7", 4, 16'h0101, 64'hAAAA0000BBBB1111, '0, '0, strVec("pr"), 3, 1'b0);
    wr(0, 6, 0, 0, 1);
    expectEv("R6", 5, 16'h0001, 64'h5555666677778888, '0, '0, strVec("q"), 2, 1'b0);
  endtask

  task automatic tIgnore();  // R10
    wr(1, 0, 32'h99999999, 0, 0);
    wr(1, 6, 32'h5A, 0, 0);
    wr(1, 6, 0, 0, 0);
    wr(3, 6, 0, 0, 0);
    wr(0, 7, 32'h41, 0, 0);
    wr(0, 6, 32'h42, 5, 0);
    wr(0, 0, 32'h77777777, 0, 9);
    wr(0, 6, 0, 0, 7);
    repeat (4) @(negedge clk);
    check("R10", "no event from dropped writes", 512'(evValid), 512'(0));
    wr(0, 6, 0, 0, 0);
    expectEv("R10", 6, 16'h0000, D0, D1, D2, '0, 1, 1'b0);
  endtask

  task automatic tOverflow();  // R9 R8
    logic [511:0] m = '0;
    for (int i = 0; i < 70; i++) begin
      logic [7:0] c = 8'(8'h61 + (i % 26));
      if (i < DEPTH) m[i*8 +: 8] = c;
      wr(0, 6, 32'(c), 0, 0);
    end
    wr(0, 6, 0, 0, 0);
    expectEv("R9", 7, 16'h0000, D0, D1, D2, m, 65, 1'b1);
    sendStr(0, 0, "ok");
    wr(0, 6, 0, 0, 0);
    expectEv("R8", 8, 16'h0000, D0, D1, D2, strVec("ok"), 3, 1'b0);
  endtask

  task automatic tStall();  // R11
    sendStr(1, 0, "s");
    wr(0, 6, 0, 0, 0);
    @(negedge clk);
    wValid = 1'b1; wAddr = {2'd0, 3'd6, 2'b00}; wData = 0; wCluster = 1; wCpu = 0;
    #1;
    check("R11", "wReady held low", 512'(wReady), 512'(0));
    repeat (2) begin
      @(negedge clk);
      check("R11", "wReady still low", 512'(wReady), 512'(0));
      check("R11", "pending seq stable", 512'(evSeq), 512'(9));
      check("R11", "pending valid", 512'(evValid), 512'(1));
    end
    @(negedge clk);
    evReady = 1'b1;
    #1;
    check("R11", "wReady when taken", 512'(wReady), 512'(1));
    @(posedge clk);
    #1 begin wValid = 1'b0; evReady = 1'b0; end
    expectEv("R11", 10, 16'h0100, '0, '0, '0, strVec("s"), 2, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tBasic();
    tPersist();
    tBanks();
    tIgnore();
    tOverflow();
    tStall();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule